// File: doc/BRIEF.md
# Overlay Pixel Key and Fill Generator

This block serves one video channel of an on-screen overlay. A bitmap of 4-bit pixels, 1024 pixels wide and 512 lines tall, sits in external memory. Each 16-bit memory word packs four horizontally adjacent pixels. The block fetches the words of the current line through a request/valid port and unpacks them pixel by pixel. For every pixel it produces a gray-level fill code and an active-low key that tells a downstream video mux to replace the camera video with the fill. A pixel code of zero is transparent and leaves the key high. Codes 1 (near black) to 15 (full white) pull the key low and appear on the fill output.

A separate timing source supplies a line-start strobe and a field-start strobe. The block counts pixels and lines from these strobes and crops the logical bitmap to the visible window of the selected standard. The window is 712 pixels by 484 lines for the 525-line standard and 712 pixels by 512 lines for the 625-line standard. All other positions are forced transparent, whatever the stored data holds. After each line start there is a short lead-in of LEAD pixel clocks, in which the first word is fetched and loaded. A one-word prefetch register then keeps the next four pixels ready while the current word shifts out. Key and fill leave the block from the same register stage.

Top module: `osd_key_fill`

## Requirements
- R1: While reset is asserted and until the first line is shown, key_n is 1 and fill is 0. mem_req is 0 during reset.
- R2: Pixel x of line y comes from the memory word at address y*256 + x/4 (mem_addr = {line[8:0], word[7:0]}). Within that word, nibble x%4 holds the pixel, and bits [3:0] are the leftmost pixel.
- R3: A nonzero visible pixel code appears on fill with key_n = 0 in the same cycle. Code 0 gives fill = 0 and key_n = 1.
- R4: Pixel x of a line reaches the outputs LEAD+x+1 rising edges after the edge that samples line_start, where LEAD defaults to 4.
- R5: The lead-in positions, the pixels 712 to 1023 and any position after pixel 1023 give key_n = 1 and fill = 0.
- R6: With std_pal = 0, lines 484 to 511 are blank. With std_pal = 1, all 512 lines are visible. A blank line issues no memory request.
- R7: field_start, given together with the first line_start of a field, sets the line count to 0. Each later line_start advances it by one. The count saturates past line 511, and positions on or after the saturated count are blank. Before the first field_start every line is blank.
- R8: mem_req stays high with a stable mem_addr until mem_valid is seen. A visible line fetches exactly 178 words, and at most one word is held ahead of the word being shifted out.
- R9: A line_start in the middle of a line restarts fetching and output cleanly. Buffered words of the old line are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| field_start | input | 1 | One-cycle strobe at the start of a field, given together with that field's first line_start |
| std_pal | input | 1 | Standard select: 0 = 484 visible lines, 1 = 512 visible lines |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | 17 | Word address: {line, word index within line} |
| mem_valid | input | 1 | Memory has placed the requested word on mem_data |
| mem_data | input | 16 | Four packed pixels, leftmost pixel in bits [3:0] |
| key_n | output | 1 | Active-low insert key for the current pixel |
| fill | output | 4 | Gray-level fill code for the current pixel |

## Verification
Some rules are checked by assertions on every clock. These are the phase and line counters clearing after their strobes, a pending request holding its address, a restart emptying the buffers, the shifter bound, and blank positions producing a transparent output in the next cycle. The other behaviours can only be shown by the bench's scenarios. These are the nibble order and address mapping, the exact output cycle of each pixel, the crop at 712 pixels and at the line limit of each standard, the saturation of the line count, the word count per line under both fast and slow memory, and the recovery from a restart in mid-line.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int PIX_W   = 4;
  localparam int WORD_W  = 16;
  localparam int PIX_PER_WORD = WORD_W / PIX_W;
  localparam int SH_CNT_W = $clog2(PIX_PER_WORD + 1);
endpackage

// File: rtl/osd_timing.sv
module osd_timing #(
  parameter int H_LOGICAL  = 1024,
  parameter int H_VISIBLE  = 712,
  parameter int V_LOGICAL  = 512,
  parameter int V_VIS_NTSC = 484,
  parameter int V_VIS_PAL  = 512,
  parameter int LEAD       = 4,
  localparam int PH_END    = LEAD + H_LOGICAL,
  localparam int PH_W      = $clog2(PH_END + 1),
  localparam int V_W       = $clog2(V_LOGICAL + 1),
  localparam int LN_W      = $clog2(V_LOGICAL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_start,
  input  logic            field_start,
  input  logic            std_pal,
  output logic [LN_W-1:0] line_idx,
  output logic            line_vis,
  output logic            pix_vis
);
  logic [PH_W-1:0] ph_q, ph_d;
  logic [V_W-1:0]  v_q, v_d;

  always_comb begin
    ph_d = ph_q;
    if (line_start)
      ph_d = '0;
    else if (ph_q != PH_W'(PH_END))
      ph_d = ph_q + 1'b1;
    v_d = v_q;
    if (field_start)
      v_d = '0;
    else if (line_start && (v_q != V_W'(V_LOGICAL)))
      v_d = v_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_W'(PH_END);
      v_q  <= V_W'(V_LOGICAL);
    end else begin
      ph_q <= ph_d;
      v_q  <= v_d;
    end
  end

  assign line_vis = v_q < (std_pal ? V_W'(V_VIS_PAL) : V_W'(V_VIS_NTSC));
  assign pix_vis  = line_vis && (ph_q >= PH_W'(LEAD)) && (ph_q < PH_W'(LEAD + H_VISIBLE));
  assign line_idx = v_q[LN_W-1:0];

  // R4: phase restarts on every line strobe
  a_r4_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (ph_q == '0));
  // R7: field strobe zeroes the line count
  a_r7_field_zero: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (v_q == '0));
endmodule

// File: rtl/osd_fetch.sv
module osd_fetch
  import osd_pkg::*;
#(
  parameter int H_LOGICAL = 1024,
  parameter int H_VISIBLE = 712,
  parameter int V_LOGICAL = 512,
  localparam int WORDS_LINE = H_LOGICAL / PIX_PER_WORD,
  localparam int WC_W       = $clog2(WORDS_LINE),
  localparam int VIS_WORDS  = H_VISIBLE / PIX_PER_WORD,
  localparam int WCNT_W     = $clog2(VIS_WORDS + 1),
  localparam int LN_W       = $clog2(V_LOGICAL),
  localparam int ADDR_W     = LN_W + WC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              line_vis,
  input  logic [LN_W-1:0]   line_idx,
  input  logic              consume,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_data,
  output logic [PIX_W-1:0]  nib,
  output logic              nib_ok
);
  logic [WCNT_W-1:0]   wcnt_q, wcnt_d;
  logic [WORD_W-1:0]   pf_q, pf_d, sh_q, sh_d;
  logic                pf_full_q, pf_full_d;
  logic [SH_CNT_W-1:0] sh_cnt_q, sh_cnt_d;
  logic                take, need_load;

  assign mem_req   = line_vis && !pf_full_q && (wcnt_q < WCNT_W'(VIS_WORDS));
  assign mem_addr  = {line_idx, WC_W'(wcnt_q)};
  assign nib       = sh_q[PIX_W-1:0];
  assign nib_ok    = (sh_cnt_q != '0);
  assign take      = consume && nib_ok;
  assign need_load = pf_full_q &&
                     ((sh_cnt_q == '0) || ((sh_cnt_q == SH_CNT_W'(1)) && consume));

  always_comb begin
    wcnt_d    = wcnt_q;
    pf_d      = pf_q;
    pf_full_d = pf_full_q;
    sh_d      = sh_q;
    sh_cnt_d  = sh_cnt_q;
    if (restart) begin
      wcnt_d    = '0;
      pf_full_d = 1'b0;
      sh_cnt_d  = '0;
    end else begin
      if (need_load) begin
        sh_d     = pf_q;
        sh_cnt_d = SH_CNT_W'(PIX_PER_WORD);
      end else if (take) begin
        sh_d     = sh_q >> PIX_W;
        sh_cnt_d = sh_cnt_q - 1'b1;
      end
      if (mem_req && mem_valid) begin
        pf_d      = mem_data;
        pf_full_d = 1'b1;
        wcnt_d    = wcnt_q + 1'b1;
      end else if (need_load) begin
        pf_full_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q    <= '0;
      pf_q      <= '0;
      pf_full_q <= 1'b0;
      sh_q      <= '0;
      sh_cnt_q  <= '0;
    end else begin
      wcnt_q    <= wcnt_d;
      pf_q      <= pf_d;
      pf_full_q <= pf_full_d;
      sh_q      <= sh_d;
      sh_cnt_q  <= sh_cnt_d;
    end
  end

  // R8: an unanswered request holds its address
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid && !restart) |=> (mem_req && $stable(mem_addr)));
  // R9: restart empties both word buffers
  a_r9_restart_empties: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!pf_full_q && (sh_cnt_q == '0)));
  // R2: never more pixels pending than one word holds
  a_r2_shift_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sh_cnt_q <= SH_CNT_W'(PIX_PER_WORD));
endmodule

// File: rtl/osd_out.sv
module osd_out
  import osd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vis,
  input  logic [PIX_W-1:0] nib,
  input  logic             nib_ok,
  output logic             key_n,
  output logic [PIX_W-1:0] fill
);
  logic [PIX_W-1:0] code;

  assign code = (pix_vis && nib_ok) ? nib : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_n <= 1'b1;
      fill  <= '0;
    end else begin
      key_n <= (code == '0);
      fill  <= code;
    end
  end

  // R5: a blank position yields a transparent output next cycle
  a_r5_blank_out: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vis |=> (key_n && (fill == '0)));
endmodule

// File: rtl/osd_key_fill.sv
module osd_key_fill
  import osd_pkg::*;
#(
  parameter int H_LOGICAL  = 1024,
  parameter int H_VISIBLE  = 712,
  parameter int V_LOGICAL  = 512,
  parameter int V_VIS_NTSC = 484,
  parameter int V_VIS_PAL  = 512,
  parameter int LEAD       = 4,
  localparam int LN_W   = $clog2(V_LOGICAL),
  localparam int ADDR_W = LN_W + $clog2(H_LOGICAL / PIX_PER_WORD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              field_start,
  input  logic              std_pal,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_data,
  output logic              key_n,
  output logic [PIX_W-1:0]  fill
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [LN_W-1:0]  line_idx;
  logic             line_vis, pix_vis, nib_ok;
  logic [PIX_W-1:0] nib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  osd_timing #(
    .H_LOGICAL(H_LOGICAL), .H_VISIBLE(H_VISIBLE), .V_LOGICAL(V_LOGICAL),
    .V_VIS_NTSC(V_VIS_NTSC), .V_VIS_PAL(V_VIS_PAL), .LEAD(LEAD)
  ) u_timing (
    .clk(clk), .rst_n(rst_core_n), .line_start(line_start),
    .field_start(field_start), .std_pal(std_pal),
    .line_idx(line_idx), .line_vis(line_vis), .pix_vis(pix_vis)
  );

  osd_fetch #(
    .H_LOGICAL(H_LOGICAL), .H_VISIBLE(H_VISIBLE), .V_LOGICAL(V_LOGICAL)
  ) u_fetch (
    .clk(clk), .rst_n(rst_core_n), .restart(line_start | field_start),
    .line_vis(line_vis), .line_idx(line_idx), .consume(pix_vis),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_data(mem_data), .nib(nib), .nib_ok(nib_ok)
  );

  osd_out u_out (
    .clk(clk), .rst_n(rst_core_n), .pix_vis(pix_vis), .nib(nib),
    .nib_ok(nib_ok), .key_n(key_n), .fill(fill)
  );
endmodule

// File: tb/osd_key_fill_tb.sv
module osd_key_fill_tb;
  localparam int CLK_P = 10;
  localparam int LEAD  = 4;
  localparam int H_LOG = 1024;

  typedef struct packed {
    logic        pal;
    logic        slow;
    logic [15:0] line;
  } vec_t;

  // pal, slow memory, target line
  localparam vec_t VECS [10] = '{
    '{1'b0, 1'b0, 16'd0},    // R2 R3 R4 R5 first line
    '{1'b0, 1'b1, 16'd5},    // R8 slow memory
    '{1'b0, 1'b0, 16'd483},  // R6 last 525-line row
    '{1'b0, 1'b0, 16'd484},  // R6 first blank row
    '{1'b0, 1'b0, 16'd511},  // R6 blank tail
    '{1'b1, 1'b0, 16'd484},  // R6 625-line row shown
    '{1'b1, 1'b1, 16'd511},  // R6 last 625-line row
    '{1'b1, 1'b1, 16'd300},  // R2 mid field
    '{1'b0, 1'b0, 16'd600},  // R7 saturation
    '{1'b1, 1'b0, 16'd520}   // R7 saturation
  };

  logic        clk = 1'b0;
  logic        rst_n, line_start, field_start, std_pal;
  logic        mem_req, mem_valid, key_n, slow_mem, req_d;
  logic [16:0] mem_addr;
  logic [15:0] mem_data;
  logic [3:0]  fill;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] pat(input logic [16:0] a);
    return {a[3:0] ^ a[12:9], 4'hF, a[7:4] ^ a[11:8], 4'h0};
  endfunction

  function automatic logic [3:0] exp_code(input logic pal, input int line, input int x);
    logic [15:0] w;
    if (line < 0 || line >= 512) return 4'd0;
    if (!pal && line >= 484) return 4'd0;
    if (x < 0 || x >= 712) return 4'd0;
    w = pat(17'(line * 256 + x / 4));
    return w[4*(x%4) +: 4];
  endfunction

  always_ff @(posedge clk) req_d <= mem_req;
  assign mem_valid = mem_req && (!slow_mem || req_d);
  assign mem_data  = pat(mem_addr);

  osd_key_fill u_dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_start(field_start),
    .std_pal(std_pal), .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_data(mem_data), .key_n(key_n), .fill(fill)
  );

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic pulse(input logic fld);
    @(negedge clk);
    field_start = fld;
    line_start  = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
    line_start  = 1'b0;
  endtask

  // Starts a line and checks every output cycle of it.
  task automatic watch(input logic fld, input int eline, input string tag);
    int bad = 0, words = 0, exp_words, bx = 0;
    logic pend = 1'b0;
    logic [16:0] paddr = '0;
    logic [3:0] e, bact = '0, bexp = '0;
    logic bkey = 1'b0;
    @(negedge clk);
    field_start = fld;
    line_start  = 1'b1;
    for (int k = 0; k <= LEAD + H_LOG + 3; k++) begin
      @(negedge clk);
      if (k == 0) begin
        field_start = 1'b0;
        line_start  = 1'b0;
      end
      #1;
      if (pend && !(mem_req && mem_addr == paddr)) bad++;
      if (mem_req && mem_valid) words++;
      pend  = mem_req && !mem_valid;
      paddr = mem_addr;
      if (k >= 1) begin
        e = exp_code(std_pal, eline, k - LEAD - 1);
        if (fill !== e || key_n !== (e == 4'd0)) begin
          if (bad == 0) begin
            bx = k - LEAD - 1; bact = fill; bexp = e; bkey = key_n;
          end
          bad++;
        end
      end
    end
    exp_words = (exp_code(std_pal, eline, 3) != 4'd0 ||
                 (eline >= 0 && eline < (std_pal ? 512 : 484))) ? 178 : 0;
    checks++;
    if (bad != 0 || words != exp_words) begin
      fails++;
      $display("FAIL %s line %0d: x=%0d fill=%0d key_n=%0d expected fill=%0d key_n=%0d, words=%0d expected %0d, errors=%0d",
               tag, eline, bx, bact, bkey, bexp, (bexp == 4'd0), words, exp_words, bad);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; line_start = 1'b0; field_start = 1'b0;
    std_pal = 1'b0; slow_mem = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(key_n === 1'b1, $sformatf("R1 reset key_n actual=%0b expected=1", key_n));
    check(fill === 4'd0, $sformatf("R1 reset fill actual=%0d expected=0", fill));
    check(mem_req === 1'b0, $sformatf("R1 reset mem_req actual=%0b expected=0", mem_req));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R7: no field strobe yet, line stays blank and fetch-free
    watch(1'b0, -1, "R7 before first field");
    // main vector table
    for (int i = 0; i < 10; i++) begin
      std_pal  = VECS[i].pal;
      slow_mem = VECS[i].slow;
      if (VECS[i].line == 16'd0) begin
        watch(1'b1, 0, "R2 R3 R4 R5 table");
      end else begin
        pulse(1'b1);
        for (int j = 1; j < int'(VECS[i].line); j++) pulse(1'b0);
        watch(1'b0, int'(VECS[i].line), "R2 R3 R4 R6 R7 R8 table");
      end
    end
    // R9: restart in mid-line with slow memory
    std_pal  = 1'b0;
    slow_mem = 1'b1;
    pulse(1'b1);
    for (int j = 1; j <= 10; j++) pulse(1'b0);
    repeat (100) @(negedge clk);
    watch(1'b0, 11, "R9 mid-line restart");
    // R1: outputs idle after the line ends
    repeat (5) @(negedge clk);
    check(key_n === 1'b1 && fill === 4'd0,
          $sformatf("R1 idle output actual key_n=%0b fill=%0d expected key_n=1 fill=0", key_n, fill));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule